// File: doc/BRIEF.md
# Beam Search Candidate Expansion Step

This block carries out one extension step of a beam-search decoder for a hash-based rateless code. It keeps a small set of surviving partial paths, each with an accumulated cost and a 64-bit chain state. For every survivor it tries every possible next k-bit message segment. For each child it derives a new chain state with a mixing function and reads a constellation point from the low bits of that state. The squared Euclidean distance between that point and the received I/Q symbol is added to the parent's cost.

One step starts when a received symbol is accepted on the input handshake. The survivors' costs and chain states are sampled in that same cycle. The block then streams out BEAMS·2^SEG_W candidates, one per output handshake. Each candidate carries its parent slot and its segment value, so that a later sorting and backtracking stage can rebuild the path. On the first step of a packet the survivors are replaced by a fixed seed state with zero cost. Lower cost means a more likely path.

Top module: `beam_acs_step`

## Requirements
- R1: Out of reset, `sym_ready` is 1 and `cand_valid` is 0.
- R2: A symbol is taken at a clock edge where `sym_valid` and `sym_ready` are both 1. From the next cycle `sym_ready` stays 0 until the final candidate of the step has been handed off, and any symbol offered during that time is ignored.
- R3: Candidates leave in ascending order of index n = parent·2^SEG_W + segment, with n running from 0 to 31 for the defaults. `cand_parent` is n[4:3] and `cand_seg` is n[2:0]. `cand_last` is 1 only for n = 31. `sym_ready` returns to 1 in the cycle after that candidate is handed off.
- R4: `cand_spine` = mix(parent state, segment), computed as follows. First a = s + zero-extended segment + 0x9E3779B97F4A7C15. Then b = a xor rotl(a,13). Then c = b + 0xC2B2AE3D27D4EB4F. The result is c xor rotl(c,27). All arithmetic is modulo 2^64.
- R5: The expected point takes its I index from `cand_spine[3:0]` and its Q index from `cand_spine[7:4]`. Each index x maps to the signed level 16·x − 120.
- R6: `cand_cost` = parent cost + (I − level_I)² + (Q − level_Q)². I and Q are signed 8-bit values. The sum saturates at 2^20 − 1 and never wraps.
- R7: When `first_step` is 1 at acceptance, every parent slot uses the seed state SEED_SPINE (default 0x0123456789ABCDEF) with cost 0, and `par_cost`/`par_spine` are ignored.
- R8: While `cand_valid` is 1 and `cand_ready` is 0, every candidate output holds its value into the next cycle.
- R9: `par_cost`, `par_spine`, `first_step`, `sym_i` and `sym_q` are sampled only at acceptance. Changing them during a step does not alter the candidates of that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Received symbol offered |
| sym_ready | output | 1 | Block can take a symbol |
| sym_i | input | 8 | Received in-phase value, signed |
| sym_q | input | 8 | Received quadrature value, signed |
| first_step | input | 1 | Use seed state and zero cost for all parents |
| par_cost | input | BEAMS·COST_W | Survivor costs, slot b at bits [b·COST_W +: COST_W] |
| par_spine | input | BEAMS·64 | Survivor chain states, slot b at bits [b·64 +: 64] |
| cand_valid | output | 1 | Candidate present |
| cand_ready | input | 1 | Downstream takes the candidate |
| cand_cost | output | COST_W | Accumulated cost of the candidate |
| cand_spine | output | 64 | Child chain state |
| cand_parent | output | log2(BEAMS) | Parent slot mark |
| cand_seg | output | SEG_W | Segment value mark |
| cand_last | output | 1 | Final candidate of the step |

## Verification
The saturation limit is the hardest case to reach. Random survivor costs almost never come close enough to 2^20 − 1 for a distance to overflow them. The stimulus therefore includes steps whose parent costs sit a few hundred counts below the limit, paired with extreme symbols such as −128/127, and these overflow for most children. The sampling-window rule is covered as well. For that, a new symbol stays offered and all survivor inputs are scrambled for the whole output stream, with random downstream stalls.

// File: rtl/beam_acs_pkg.sv
package beam_acs_pkg;

  localparam int SPINE_W  = 64;
  localparam int SYM_W    = 8;
  localparam int PIDX_W   = 4;
  localparam int LVL_W    = 9;
  localparam int DIFF_W   = 10;
  localparam int METRIC_W = 18;
  localparam int ROT_A    = 13;
  localparam int ROT_B    = 27;

  localparam logic [SPINE_W-1:0] MIX_C1 = 64'h9E3779B97F4A7C15;
  localparam logic [SPINE_W-1:0] MIX_C2 = 64'hC2B2AE3D27D4EB4F;

  function automatic logic [SPINE_W-1:0] rotl(input logic [SPINE_W-1:0] x, input int n);
    return (x << n) | (x >> (SPINE_W - n));
  endfunction

  // Chain-state mixing: add, xor-rotate, add, xor-rotate.
  function automatic logic [SPINE_W-1:0] spine_mix(input logic [SPINE_W-1:0] parent,
                                                   input logic [SPINE_W-1:0] seg_ext);
    logic [SPINE_W-1:0] a, b, c;
    a = parent + seg_ext + MIX_C1;
    b = a ^ rotl(a, ROT_A);
    c = b + MIX_C2;
    return c ^ rotl(c, ROT_B);
  endfunction

  // Linear 16-level axis: 16*idx - 120.
  function automatic logic signed [LVL_W-1:0] level_of(input logic [PIDX_W-1:0] idx);
    return $signed({1'b0, idx, 4'b0000}) - 9'sd120;
  endfunction

  function automatic logic [METRIC_W-1:0] sq_dist(input logic signed [SYM_W-1:0] yi,
                                                  input logic signed [SYM_W-1:0] yq,
                                                  input logic signed [LVL_W-1:0] li,
                                                  input logic signed [LVL_W-1:0] lq);
    logic signed [DIFF_W-1:0]   di, dq;
    logic signed [2*DIFF_W-1:0] pi, pq, tot;
    di  = DIFF_W'(yi) - DIFF_W'(li);
    dq  = DIFF_W'(yq) - DIFF_W'(lq);
    pi  = di * di;
    pq  = dq * dq;
    tot = pi + pq;
    return METRIC_W'(tot);
  endfunction

endpackage

// File: rtl/beam_acs_seq.sv
module beam_acs_seq #(
  parameter int N_CAND = 32,
  parameter int IDX_W  = $clog2(N_CAND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             cand_ready,
  output logic             sym_ready,
  output logic             take,
  output logic             cand_valid,
  output logic             fire,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CAND - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign sym_ready  = !busy_q;
  assign take       = sym_valid && !busy_q;
  assign cand_valid = busy_q;
  assign fire       = busy_q && cand_ready;
  assign idx        = idx_q;
  assign last       = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (fire) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cand_valid && idx == '0 && !sym_ready));
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (cand_valid && idx == $past(idx) + 1'b1));
  a_r3_end_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (sym_ready && !cand_valid));
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_ready) |=> (cand_valid && $stable(idx)));

endmodule

// File: rtl/beam_acs_store.sv
module beam_acs_store
  import beam_acs_pkg::*;
#(
  parameter int                 BEAMS      = 4,
  parameter int                 COST_W     = 20,
  parameter int                 PAR_W      = $clog2(BEAMS),
  parameter logic [SPINE_W-1:0] SEED_SPINE = 64'h0123456789ABCDEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic                       first_step,
  input  logic [SYM_W-1:0]           sym_i,
  input  logic [SYM_W-1:0]           sym_q,
  input  logic [BEAMS*COST_W-1:0]    par_cost,
  input  logic [BEAMS*SPINE_W-1:0]   par_spine,
  input  logic [PAR_W-1:0]           sel,
  output logic [SYM_W-1:0]           cur_i,
  output logic [SYM_W-1:0]           cur_q,
  output logic [COST_W-1:0]          sel_cost,
  output logic [SPINE_W-1:0]         sel_spine
);
  logic [COST_W-1:0]  cost_q  [BEAMS];
  logic [SPINE_W-1:0] spine_q [BEAMS];
  logic [SYM_W-1:0]   i_q, q_q;

  for (genvar b = 0; b < BEAMS; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cost_q[b]  <= '0;
        spine_q[b] <= SEED_SPINE;
      end else if (take) begin
        cost_q[b]  <= first_step ? '0 : par_cost[b*COST_W +: COST_W];
        spine_q[b] <= first_step ? SEED_SPINE : par_spine[b*SPINE_W +: SPINE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_q <= '0;
      q_q <= '0;
    end else if (take) begin
      i_q <= sym_i;
      q_q <= sym_q;
    end
  end

  assign cur_i     = i_q;
  assign cur_q     = q_q;
  assign sel_cost  = cost_q[sel];
  assign sel_spine = spine_q[sel];

  a_r7_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    (take && first_step) |=> (spine_q[0] == SEED_SPINE && cost_q[0] == '0
                              && spine_q[BEAMS-1] == SEED_SPINE));
  a_r9_window: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(i_q) && $stable(q_q) && $stable(cost_q[0]) && $stable(spine_q[0])));

endmodule

// File: rtl/beam_acs_branch.sv
module beam_acs_branch
  import beam_acs_pkg::*;
#(
  parameter int COST_W = 20,
  parameter int SEG_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic [COST_W-1:0]          par_cost,
  input  logic [SPINE_W-1:0]         par_spine,
  input  logic [SEG_W-1:0]           seg,
  input  logic [SYM_W-1:0]           yi,
  input  logic [SYM_W-1:0]           yq,
  output logic [SPINE_W-1:0]         child_spine,
  output logic [COST_W-1:0]          child_cost
);
  localparam logic [COST_W-1:0] COST_MAX = '1;

  logic signed [LVL_W-1:0] lvl_i, lvl_q;
  logic [METRIC_W-1:0]     metric;
  logic [COST_W:0]         raw_sum;
  logic                    sat_hit;

  assign child_spine = spine_mix(par_spine, SPINE_W'(seg));
  assign lvl_i       = level_of(child_spine[PIDX_W-1:0]);
  assign lvl_q       = level_of(child_spine[2*PIDX_W-1:PIDX_W]);
  assign metric      = sq_dist($signed(yi), $signed(yq), lvl_i, lvl_q);
  assign raw_sum     = {1'b0, par_cost} + (COST_W+1)'(metric);
  assign sat_hit     = raw_sum[COST_W];
  assign child_cost  = sat_hit ? COST_MAX : raw_sum[COST_W-1:0];

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (child_cost >= par_cost));
  a_r6_pinned_max: assert property (@(posedge clk) disable iff (!rst_n)
    (active && par_cost == COST_MAX) |-> (child_cost == COST_MAX));
  a_r5_levels_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (lvl_i >= -9'sd120 && lvl_i <= 9'sd120 && lvl_q >= -9'sd120 && lvl_q <= 9'sd120));

endmodule

// File: rtl/beam_acs_step.sv
module beam_acs_step
  import beam_acs_pkg::*;
#(
  parameter int                 BEAMS      = 4,
  parameter int                 SEG_W      = 3,
  parameter int                 COST_W     = 20,
  parameter logic [SPINE_W-1:0] SEED_SPINE = 64'h0123456789ABCDEF,
  parameter int                 PAR_W      = $clog2(BEAMS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sym_valid,
  output logic                     sym_ready,
  input  logic [SYM_W-1:0]         sym_i,
  input  logic [SYM_W-1:0]         sym_q,
  input  logic                     first_step,
  input  logic [BEAMS*COST_W-1:0]  par_cost,
  input  logic [BEAMS*SPINE_W-1:0] par_spine,
  output logic                     cand_valid,
  input  logic                     cand_ready,
  output logic [COST_W-1:0]        cand_cost,
  output logic [SPINE_W-1:0]       cand_spine,
  output logic [PAR_W-1:0]         cand_parent,
  output logic [SEG_W-1:0]         cand_seg,
  output logic                     cand_last
);
  localparam int N_CAND = BEAMS * (1 << SEG_W);
  localparam int IDX_W  = PAR_W + SEG_W;

  logic             take, fire;
  logic [IDX_W-1:0] idx;
  logic [SYM_W-1:0] cur_i, cur_q;
  logic [COST_W-1:0]  sel_cost;
  logic [SPINE_W-1:0] sel_spine;

  beam_acs_seq #(.N_CAND(N_CAND), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .cand_ready(cand_ready),
    .sym_ready(sym_ready), .take(take), .cand_valid(cand_valid), .fire(fire),
    .idx(idx), .last(cand_last)
  );

  assign cand_parent = idx[IDX_W-1:SEG_W];
  assign cand_seg    = idx[SEG_W-1:0];

  beam_acs_store #(.BEAMS(BEAMS), .COST_W(COST_W), .PAR_W(PAR_W), .SEED_SPINE(SEED_SPINE)) u_store (
    .clk(clk), .rst_n(rst_n), .take(take), .first_step(first_step),
    .sym_i(sym_i), .sym_q(sym_q), .par_cost(par_cost), .par_spine(par_spine),
    .sel(cand_parent), .cur_i(cur_i), .cur_q(cur_q),
    .sel_cost(sel_cost), .sel_spine(sel_spine)
  );

  beam_acs_branch #(.COST_W(COST_W), .SEG_W(SEG_W)) u_branch (
    .clk(clk), .rst_n(rst_n), .active(cand_valid),
    .par_cost(sel_cost), .par_spine(sel_spine), .seg(cand_seg),
    .yi(cur_i), .yq(cur_q), .child_spine(cand_spine), .child_cost(cand_cost)
  );

  a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_ready) |=> ($stable(cand_cost) && $stable(cand_spine)
                                     && $stable(cand_parent) && $stable(cand_seg)));
  a_r3_last_mark: assert property (@(posedge clk) disable iff (!rst_n)
    cand_last |-> (cand_parent == PAR_W'(BEAMS-1) && cand_seg == '1));

endmodule

// File: tb/test_beam_acs_step.sv
module test_beam_acs_step;
  localparam int B  = 4;
  localparam int K  = 3;
  localparam int CW = 20;
  localparam int NC = 32;
  localparam logic [63:0] SEED = 64'h0123456789ABCDEF;
  localparam logic [CW-1:0] CMAX = '1;

  typedef logic [CW-1:0] cost_arr_t [B];
  typedef logic [63:0]   spine_arr_t [B];

  logic clk = 1'b0, rst_n = 1'b0;
  logic sym_valid = 1'b0, cand_ready = 1'b0, first_step = 1'b0;
  logic [7:0] sym_i = '0, sym_q = '0;
  logic [B*CW-1:0] par_cost = '0;
  logic [B*64-1:0] par_spine = '0;
  logic sym_ready, cand_valid, cand_last;
  logic [CW-1:0] cand_cost;
  logic [63:0] cand_spine;
  logic [1:0] cand_parent;
  logic [K-1:0] cand_seg;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  beam_acs_step #(.BEAMS(B), .SEG_W(K), .COST_W(CW), .SEED_SPINE(SEED)) i_beam_acs_step (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_i(sym_i), .sym_q(sym_q), .first_step(first_step),
    .par_cost(par_cost), .par_spine(par_spine),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_cost(cand_cost),
    .cand_spine(cand_spine), .cand_parent(cand_parent), .cand_seg(cand_seg),
    .cand_last(cand_last)
  );

  function automatic logic [63:0] ref_mix(input logic [63:0] s, input int seg);
    logic [63:0] a, b, c;
    a = s + 64'(seg) + 64'h9E3779B97F4A7C15;
    b = a ^ {a[50:0], a[63:51]};
    c = b + 64'hC2B2AE3D27D4EB4F;
    return c ^ {c[36:0], c[63:37]};
  endfunction

  function automatic longint ref_cost(input longint pc, input logic [63:0] ch, input int yi, input int yq);
    int li, lq;
    longint tot;
    li  = int'(ch[3:0]) * 16 - 120;
    lq  = int'(ch[7:4]) * 16 - 120;
    tot = pc + longint'((yi - li) * (yi - li)) + longint'((yq - lq) * (yq - lq));
    if (tot > longint'(CMAX)) tot = longint'(CMAX);
    return tot;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_step(input bit first, input cost_arr_t costs, input spine_arr_t spines,
                          input int yi, input int yq, input int stall_pct);
    int n = 0, guard = 0;
    bit held = 0;
    logic [CW-1:0] h_cost;
    logic [63:0]   h_spine;
    logic [1:0]    h_par;
    logic [K-1:0]  h_seg;
    @(negedge clk);
    first_step = first;
    sym_i = 8'(yi);
    sym_q = 8'(yq);
    for (int b = 0; b < B; b++) begin
      par_cost[b*CW +: CW] = costs[b];
      par_spine[b*64 +: 64] = spines[b];
    end
    sym_valid = 1'b1;
    while (!sym_ready) @(negedge clk);
    @(negedge clk);
    // R9 / R2: scramble all sampled inputs and keep offering a symbol during the stream
    first_step = ~first;
    sym_i = 8'($urandom);
    sym_q = 8'($urandom);
    par_cost = {$urandom, $urandom, $urandom};
    par_spine = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    while (n < NC && guard < 2000) begin
      bit rdy;
      guard++;
      check(sym_ready == 1'b0, "R2", "sym_ready while streaming", sym_ready, 0);
      if (held) begin
        check(cand_cost == h_cost && cand_spine == h_spine && cand_parent == h_par
              && cand_seg == h_seg, "R8", "stalled outputs held", cand_cost, h_cost);
      end
      rdy = ($urandom_range(99) >= stall_pct);
      cand_ready = rdy;
      if (!cand_valid) begin
        check(1'b0, "R2", "cand_valid during step", 0, 1);
      end else if (rdy) begin
        int p, s;
        logic [63:0] base_s, ch;
        longint base_c, ec;
        p = n / 8;
        s = n % 8;
        base_s = first ? SEED : spines[p];
        base_c = first ? 0 : longint'(costs[p]);
        ch = ref_mix(base_s, s);
        ec = ref_cost(base_c, ch, yi, yq);
        check(cand_parent == 2'(p), "R3", "parent mark", cand_parent, p);
        check(cand_seg == K'(s), "R3", "segment mark", cand_seg, s);
        check(cand_last == (n == NC - 1), "R3", "last flag", cand_last, n == NC - 1);
        check(cand_spine == ch, first ? "R7" : "R4", "child spine", cand_spine, ch);
        check(longint'(cand_cost) == ec, first ? "R7" : "R6", "cost (R5 point)", cand_cost, ec);
        n++;
        held = 0;
      end else begin
        held = 1;
        h_cost = cand_cost; h_spine = cand_spine; h_par = cand_parent; h_seg = cand_seg;
      end
      @(negedge clk);
    end
    check(n == NC, "R3", "candidate count", n, NC);
    check(sym_ready == 1'b1 && cand_valid == 1'b0, "R3", "ready after last", sym_ready, 1);
    sym_valid = 1'b0;
    cand_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cost_arr_t  c;
    spine_arr_t s;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sym_ready == 1'b1, "R1", "sym_ready after reset", sym_ready, 1);
    check(cand_valid == 1'b0, "R1", "cand_valid after reset", cand_valid, 0);

    // R7: first step, parent inputs hold junk that must be ignored
    for (int b = 0; b < B; b++) begin c[b] = CW'(1000 + b); s[b] = 64'hDEAD_0000 + 64'(b); end
    run_step(1'b1, c, s, 37, -90, 0);
    // R6: saturation with costs near the limit and extreme symbols
    for (int b = 0; b < B; b++) begin c[b] = CMAX - CW'(50 * b + 10); s[b] = {$urandom, $urandom}; end
    c[3] = CMAX;
    run_step(1'b0, c, s, -128, 127, 30);
    run_step(1'b0, c, s, 127, -128, 0);
    // R4/R5: zero symbol, zero costs
    for (int b = 0; b < B; b++) begin c[b] = '0; s[b] = 64'(b); end
    run_step(1'b0, c, s, 0, 0, 50);
    // random steps with stalls
    for (int t = 0; t < 10; t++) begin
      for (int b = 0; b < B; b++) begin
        c[b] = (t % 3 == 0) ? CMAX - CW'($urandom_range(200000)) : CW'($urandom_range(400000));
        s[b] = {$urandom, $urandom};
      end
      run_step(t == 5, c, s, int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128,
               int'($urandom_range(70)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule